// File: doc/BRIEF.md
# Wake Event Status and Enable Registers

This block holds a 16-bit sticky event status register and a 16-bit enable register for general-purpose wake sources. Hardware sources (codec wake, USB wake request, thermal alarm, thermal override, ring indicate and a generic power-management event) set status bits. Software reads either register through a small read/write port and clears status bits by writing ones. Every enabled wake-capable status bit raises a wake request. The thermal and generic power-management bits, when enabled, also raise a power-management interrupt.

All asynchronous event inputs pass through two-flop synchronizers. Pulse-style sources are edge detected. Codec wake is raised while a codec data input is high and the codec bit clock has stopped toggling for a parameterised number of reference cycles, or while the global codec interrupt flag is high. State sits in separate reset domains: a standby (resume) domain, a battery-backed (RTC) domain, a hard reset that touches only the pipeline, and a power-button override that wipes all enables.

Top module: `wake_evt_regs`

## Requirements
- R1: After the standby and battery resets, status (reg_addr=0) and enable (reg_addr=1) both read 0000h, and both outputs are low. Read data is registered and appears the cycle after the address. Only bits 0, 3, 5, 8 and 11 of the enable register are writable, and a write of FFFFh to enable reads back 0929h.
- R2: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R3: A hardware set and a write-one-to-clear of the same status bit in the same cycle leave the bit set.
- R4: Status bit 5 (codec) is set while either codec data input is high and the bit clock has not toggled for STALL_CYCLES reference cycles, or while the codec global interrupt is high. A toggling bit clock does not set it.
- R5: Status bit 5 survives the hard reset and the standby reset, and is cleared by the battery reset.
- R6: Status bit 3 is set on a rising USB wake request and is cleared by the standby reset.
- R7: Status bit 0 is set when the thermal input enters its active level (high when thrm_pol=1). Status bit 1 is set on a rising thermal override. The standby reset clears both.
- R8: wake_req, registered one cycle after the state, is the OR of status AND enable over bits 3, 5, 8 and 11. Bits 0 and 1 never raise it.
- R9: pm_irq is high when status and enable are both set in bit 0 or in bit 11. Bit 1 never raises it.
- R10: The standby reset clears enable bits 0, 3, 5 and 11 and keeps bit 8. The battery reset clears enable bits 8 to 15 and keeps bits 0 to 7.
- R11: A power-button override clears all enable bits and leaves status unchanged.
- R12: Ring indicate (status bit 8, set on a rising ring input) raises wake_req only while enable bit 8 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Hard reset, synchronous, active high; clears only the pipeline |
| rsm_rst | input | 1 | Standby-domain reset |
| rtc_rst | input | 1 | Battery-domain reset |
| pwrbtn_ovr | input | 1 | Power-button override; clears all enables |
| reg_addr | input | 1 | 0 = status, 1 = enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| codec_din | input | 2 | Codec data inputs |
| codec_bitclk | input | 1 | Codec bit clock |
| codec_gint | input | 1 | Codec global interrupt flag |
| usb_wake | input | 1 | USB wake request |
| thrm_in | input | 1 | Thermal alarm input |
| thrm_pol | input | 1 | Thermal active level (1 = high) |
| thrm_ovr | input | 1 | Thermal override throttling start |
| ring_in | input | 1 | Ring indicate |
| pme_in | input | 1 | Generic power-management event |
| wake_req | output | 1 | Registered wake request |
| pm_irq | output | 1 | Registered power-management interrupt |

## Verification
A wrong status or enable bit shows on reg_rdata one cycle after the address is presented. It shows on wake_req or pm_irq one cycle after the state goes wrong, provided the matching enable is set. A mistake on the event path shows as a status bit that comes up too early, too late or never, three reference cycles after the input changes. A codec stall miscount shows as bit 5 setting while the bit clock still toggles, or failing to set once the clock stops. Reset-domain mistakes show as bits that survive, or vanish after, a reset that should not touch them.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
  localparam int REG_W   = 16;
  localparam int B_THRM  = 0;
  localparam int B_TOVR  = 1;
  localparam int B_USB   = 3;
  localparam int B_CODEC = 5;
  localparam int B_RING  = 8;
  localparam int B_PME   = 11;
  localparam logic [REG_W-1:0] STS_MASK  = 16'h092B;
  localparam logic [REG_W-1:0] EN_MASK   = 16'h0929;
  localparam logic [REG_W-1:0] WAKE_MASK = 16'h0928;
  localparam logic [REG_W-1:0] IRQ_MASK  = 16'h0801;
  localparam logic [REG_W-1:0] RSM_STS   = 16'h000B;
  localparam logic [REG_W-1:0] RTC_STS   = 16'h0920;
  localparam logic [REG_W-1:0] RSM_EN    = 16'h08FF;
  localparam logic [REG_W-1:0] RTC_EN    = 16'hFF00;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/wake_clk_stall.sv
module wake_clk_stall #(
  parameter int STALL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_s,
  output logic stalled
);
  localparam int CW = $clog2(STALL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STALL_CYCLES);
  logic          prev;
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= bclk_s;
      if (bclk_s != prev) cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end
  assign stalled = (cnt == LIMIT);
endmodule

// File: rtl/wake_evt_regs.sv
module wake_evt_regs
  import wake_evt_pkg::*;
#(
  parameter int STALL_CYCLES = 16,
  parameter int N_EDGE       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rsm_rst,
  input  logic             rtc_rst,
  input  logic             pwrbtn_ovr,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [1:0]       codec_din,
  input  logic             codec_bitclk,
  input  logic             codec_gint,
  input  logic             usb_wake,
  input  logic             thrm_in,
  input  logic             thrm_pol,
  input  logic             thrm_ovr,
  input  logic             ring_in,
  input  logic             pme_in,
  output logic             wake_req,
  output logic             pm_irq
);
  localparam int N_SYNC = N_EDGE + 4;

  logic [N_SYNC-1:0] raw, syn;
  assign raw = {codec_bitclk, codec_din, codec_gint,
                pme_in, ring_in, thrm_ovr, thrm_in, usb_wake};

  wake_sync #(.W(N_SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  logic bclk_s, gint_s, stalled;
  logic [1:0] din_s;
  assign bclk_s = syn[N_SYNC-1];
  assign din_s  = syn[N_SYNC-2 -: 2];
  assign gint_s = syn[N_EDGE];

  wake_clk_stall #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
    .clk(clk), .rst(rst), .bclk_s(bclk_s), .stalled(stalled)
  );

  // Level view of pulse sources; thermal level adjusted by polarity
  logic [N_EDGE-1:0] lvl, lvl_q, rise;
  always_comb begin
    lvl    = syn[N_EDGE-1:0];
    lvl[1] = ~(syn[1] ^ thrm_pol);
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '1;
    else     lvl_q <= lvl;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_EDGE; gi++) begin : g_edge
      assign rise[gi] = lvl[gi] & ~lvl_q[gi];
    end
  endgenerate

  // Hardware set vector
  logic [REG_W-1:0] sts_set;
  always_comb begin
    sts_set          = '0;
    sts_set[B_USB]   = rise[0];
    sts_set[B_THRM]  = rise[1];
    sts_set[B_TOVR]  = rise[2];
    sts_set[B_RING]  = rise[3];
    sts_set[B_PME]   = rise[4];
    sts_set[B_CODEC] = gint_s | (stalled & (|din_s));
  end

  logic [REG_W-1:0] sts_q, en_q, sts_d, en_d, sts_clr;
  always_comb begin
    sts_clr = (reg_wr && !reg_addr) ? reg_wdata : '0;
    sts_d   = ((sts_q & ~sts_clr) | sts_set) & STS_MASK;
    if (rsm_rst) sts_d = sts_d & ~RSM_STS;
    if (rtc_rst) sts_d = sts_d & ~RTC_STS;

    en_d = (reg_wr && reg_addr) ? (reg_wdata & EN_MASK) : en_q;
    if (rsm_rst)    en_d = en_d & ~RSM_EN;
    if (rtc_rst)    en_d = en_d & ~RTC_EN;
    if (pwrbtn_ovr) en_d = '0;
  end

  always_ff @(posedge clk) begin
    sts_q <= sts_d;
    en_q  <= en_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      wake_req  <= 1'b0;
      pm_irq    <= 1'b0;
    end else begin
      reg_rdata <= reg_addr ? en_q : sts_q;
      wake_req  <= |(sts_q & en_q & WAKE_MASK);
      pm_irq    <= |(sts_q & en_q & IRQ_MASK);
    end
  end
endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk
  import wake_evt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rsm_rst,
  input logic             rtc_rst,
  input logic             pwrbtn_ovr,
  input logic             reg_addr,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [REG_W-1:0] sts_q,
  input logic [REG_W-1:0] en_q,
  input logic             wake_req,
  input logic             pm_irq
);
  p_rdata_reserved_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~STS_MASK & ~EN_MASK) == '0);

  p_zero_write_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr && reg_wdata == '0 && !rsm_rst && !rtc_rst)
      |=> (($past(sts_q) & ~sts_q) == '0));

  p_codec_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (sts_q[B_CODEC] && !rtc_rst && !(reg_wr && !reg_addr && reg_wdata[B_CODEC]))
      |=> sts_q[B_CODEC]);

  p_wake_source_r8: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(|(sts_q & en_q & WAKE_MASK)));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    pm_irq |-> $past((sts_q[B_THRM] & en_q[B_THRM]) | (sts_q[B_PME] & en_q[B_PME])));

  p_pwrbtn_clears_r11: assert property (@(posedge clk) disable iff (rst)
    pwrbtn_ovr |=> (en_q == '0));
endmodule

bind wake_evt_regs wake_evt_chk u_chk (
  .clk(clk), .rst(rst), .rsm_rst(rsm_rst), .rtc_rst(rtc_rst),
  .pwrbtn_ovr(pwrbtn_ovr), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_q(sts_q),
  .en_q(en_q), .wake_req(wake_req), .pm_irq(pm_irq)
);

// File: tb/tb_wake_evt_regs.sv
`timescale 1ns/1ps
module tb_wake_evt_regs;
  logic clk = 0, rst = 1, rsm_rst = 1, rtc_rst = 1, pwrbtn_ovr = 0;
  logic reg_addr = 0, reg_wr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [1:0] codec_din = 0;
  logic codec_bitclk = 0, codec_gint = 0, usb_wake = 0, thrm_in = 0;
  logic thrm_pol = 1, thrm_ovr = 0, ring_in = 0, pme_in = 0;
  logic wake_req, pm_irq;
  logic bclk_run = 1;
  int n_run = 0, n_fail = 0;
  logic [15:0] rd;

  always #5 clk = ~clk;

  wake_evt_regs dut (
    .clk(clk), .rst(rst), .rsm_rst(rsm_rst), .rtc_rst(rtc_rst),
    .pwrbtn_ovr(pwrbtn_ovr), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .codec_din(codec_din),
    .codec_bitclk(codec_bitclk), .codec_gint(codec_gint), .usb_wake(usb_wake),
    .thrm_in(thrm_in), .thrm_pol(thrm_pol), .thrm_ovr(thrm_ovr),
    .ring_in(ring_in), .pme_in(pme_in), .wake_req(wake_req), .pm_irq(pm_irq)
  );

  // bit clock: toggles every 2 reference cycles while bclk_run
  initial forever begin
    repeat (2) @(negedge clk);
    if (bclk_run) codec_bitclk = ~codec_bitclk;
  end

  // {enable write, expected enable, expected wake, expected irq} with status 092Bh
  localparam logic [33:0] TV [9] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h0001, 16'h0001, 1'b0, 1'b1},
    {16'h0002, 16'h0000, 1'b0, 1'b0},
    {16'h0008, 16'h0008, 1'b1, 1'b0},
    {16'h0020, 16'h0020, 1'b1, 1'b0},
    {16'h0100, 16'h0100, 1'b1, 1'b0},
    {16'h0800, 16'h0800, 1'b1, 1'b1},
    {16'hFFFF, 16'h0929, 1'b1, 1'b1},
    {16'hF6D6, 16'h0000, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdreg(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0; rsm_rst = 0; rtc_rst = 0;
    idle(2);
    rdreg(0, rd); chk("R1 status reset", rd, 16'h0000);
    rdreg(1, rd); chk("R1 enable reset", rd, 16'h0000);
    chk("R1 outputs reset", {14'b0, wake_req, pm_irq}, 16'h0000);

    // codec: data high, clock running -> no set
    codec_din = 2'b01; idle(40);
    rdreg(0, rd); chk("R4 running clock no set", rd, 16'h0000);
    bclk_run = 0; idle(30);
    rdreg(0, rd); chk("R4 stalled clock set", rd, 16'h0020);
    codec_din = 0; idle(4);
    wr(0, 16'h0020); idle(1);
    rdreg(0, rd); chk("R2 w1c codec", rd, 16'h0000);
    codec_gint = 1; idle(4); codec_gint = 0; idle(4);
    rdreg(0, rd); chk("R4 global interrupt", rd, 16'h0020);

    usb_wake = 1; idle(4); usb_wake = 0; idle(4);
    rdreg(0, rd); chk("R6 usb set", rd, 16'h0028);
    thrm_in = 1; idle(4); thrm_in = 0; idle(4);
    thrm_ovr = 1; idle(4); thrm_ovr = 0; idle(4);
    rdreg(0, rd); chk("R7 thermal and override", rd, 16'h002B);
    ring_in = 1; pme_in = 1; idle(4); ring_in = 0; pme_in = 0; idle(4);
    rdreg(0, rd); chk("R12 ring and pme set", rd, 16'h092B);
    wr(0, 16'h0000); idle(1);
    rdreg(0, rd); chk("R2 zero write no effect", rd, 16'h092B);

    for (int i = 0; i < 9; i++) begin
      wr(1, TV[i][33:18]);
      rdreg(1, rd); chk($sformatf("R1 enable readback %0d", i), rd, TV[i][17:2]);
      chk($sformatf("R8 wake %0d", i), {15'b0, wake_req}, {15'b0, TV[i][1]});
      chk($sformatf("R9 irq %0d", i), {15'b0, pm_irq}, {15'b0, TV[i][0]});
    end

    // R12: ring enabled, ring status cleared -> no wake
    wr(1, 16'h0100);
    wr(0, 16'h0100); idle(2);
    chk("R12 ring cleared no wake", {15'b0, wake_req}, 16'h0000);
    rdreg(0, rd); chk("R12 status after clear", rd, 16'h082B);

    // R3: set and clear in the same cycle
    wr(0, 16'h0008);
    @(negedge clk); usb_wake = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 0; reg_wdata = 16'h0008; reg_wr = 1;
    @(negedge clk); reg_wr = 0; usb_wake = 0; idle(4);
    rdreg(0, rd); chk("R3 set wins over clear", rd, 16'h082B);

    // R5, R6, R7, R10: resets
    @(negedge clk); rst = 1; idle(2); rst = 0; idle(2);
    rdreg(0, rd); chk("R5 hard reset keeps status", rd, 16'h082B);
    wr(1, 16'hFFFF);
    @(negedge clk); rsm_rst = 1; @(negedge clk); rsm_rst = 0;
    rdreg(0, rd); chk("R5 R6 R7 standby reset status", rd, 16'h0820);
    rdreg(1, rd); chk("R10 standby reset enable", rd, 16'h0100);

    wr(1, 16'hFFFF);
    @(negedge clk); pwrbtn_ovr = 1; @(negedge clk); pwrbtn_ovr = 0;
    rdreg(1, rd); chk("R11 override clears enable", rd, 16'h0000);
    rdreg(0, rd); chk("R11 override keeps status", rd, 16'h0820);

    wr(1, 16'hFFFF);
    @(negedge clk); rtc_rst = 1; @(negedge clk); rtc_rst = 0;
    rdreg(1, rd); chk("R10 battery reset enable", rd, 16'h0029);
    rdreg(0, rd); chk("R5 battery reset status", rd, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule